// File: doc/BRIEF.md
# Tile Sprite Pixel Renderer

This block picks the colour of each pixel of a 640x480 raster. The raster is cut into square tiles of 16x16 pixels. A game-state source supplies an entity code for the tile that holds the current pixel, and it supplies that code with the same timing as the pixel coordinates. The renderer takes the pixel's column and row inside its tile from the low coordinate bits. For a non-empty entity it looks up one pixel of that entity's 16x16 sprite and drives the red, green and blue bits of a 3-bit colour.

The sprite images are not stored as a written table. Small arithmetic rules generate them from the in-tile column and row. There are three sprites: a head, a tail segment and an apple. An empty tile is plain white. The colour leaves the block through a register on the pixel clock. It is black while the raster is outside its active area and black during reset. Sync timing and game state come from neighbouring blocks.

Top module: `tile_sprite_renderer`

## Requirements
- R1: While `rst_i` is high, all three colour outputs are 0. Reset acts asynchronously, so the outputs clear without waiting for a clock edge.
- R2: Inputs are sampled on a rising edge of `clk_i`. The colour for those inputs appears just after that edge, and the outputs hold their previous value until then.
- R3: When `active_i` is low the sampled colour is black (000), whatever the entity code and coordinates are. When `active_i` is high the coordinates lie within x < 640 and y < 480.
- R4: Entity code 0 (empty) gives white: red, green and blue all 1.
- R5: Entity codes are 0 empty, 1 head, 2 tail and 3 apple. The sprite column is c = x mod 16 and the sprite row is r = y mod 16. In a sprite value written as the three bits {B,G,R}, bit 0 drives `red_o`, bit 1 drives `green_o` and bit 2 drives `blue_o`.
- R6: Head sprite. Any pixel with c or r equal to 0 or 15 is green (010). Inside the border, the pixels with r in {4,5} and c in {4,5,10,11} are black (000). All other head pixels are yellow (011).
- R7: Tail sprite. The pixel is green (010) when bit 2 of c differs from bit 2 of r, and cyan (110) when the two bits are equal.
- R8: Apple sprite. The rules apply in this order: pixels with c in {7,8} and r <= 2 are green (010); otherwise pixels with (2c-15)^2 + (2r-15)^2 <= 196 are red (001); all other apple pixels are white (111).
- R9: Only the in-tile offsets affect the sprite. The same entity at the same offset in any tile of the raster gives the same colour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock, rising edge active |
| rst_i | input | 1 | Asynchronous reset, active high |
| active_i | input | 1 | High while the pixel is inside the visible raster |
| px_x_i | input | 10 | Pixel column, 0 to 639 |
| px_y_i | input | 10 | Pixel row, 0 to 479 |
| ent_i | input | 2 | Entity code of the tile holding the pixel |
| red_o | output | 1 | Registered red bit |
| green_o | output | 1 | Registered green bit |
| blue_o | output | 1 | Registered blue bit |

## Verification
Two kinds of event can land in the same clock cycle as a sprite lookup.

The first is blanking. The bench drives `active_i` low together with every entity code and with coordinates both inside and outside the raster. After the next edge it expects black, not the sprite or white colour.

The second is an asynchronous reset in the middle of a pixel stream. The bench raises reset between two clock edges while a sprite pixel is on the outputs. It checks that the outputs read 000 before the next rising edge.

The sprite sweep covers every in-tile offset of every entity in three different tiles. Each expected colour comes from the arithmetic rules above. Before each edge, the bench also checks that the previous colour is still held.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  localparam int ENT_W = 2;
  localparam int N_ENT = 1 << ENT_W;

  typedef enum logic [ENT_W-1:0] {
    ENT_EMPTY = 2'd0,
    ENT_HEAD  = 2'd1,
    ENT_TAIL  = 2'd2,
    ENT_APPLE = 2'd3
  } ent_e;

  // The first member is the MSB, so red sits at bit 0 of the packed value.
  typedef struct packed {
    logic blu;
    logic grn;
    logic red;
  } rgb_t;

  localparam rgb_t C_BLACK  = rgb_t'(3'b000);
  localparam rgb_t C_RED    = rgb_t'(3'b001);
  localparam rgb_t C_GREEN  = rgb_t'(3'b010);
  localparam rgb_t C_YELLOW = rgb_t'(3'b011);
  localparam rgb_t C_CYAN   = rgb_t'(3'b110);
  localparam rgb_t C_WHITE  = rgb_t'(3'b111);

  // Head: green frame, two dark eyes on the upper rows, yellow face.
  function automatic rgb_t head_px(int c, int r, int t);
    bit edge_hit;
    bit eye_row;
    bit eye_col;
    edge_hit = (c == 0) || (c == t - 1) || (r == 0) || (r == t - 1);
    eye_row  = (r >= t / 4) && (r <= t / 4 + 1);
    eye_col  = ((c >= t / 4) && (c <= t / 4 + 1)) ||
               ((c >= t - t / 4 - 2) && (c <= t - t / 4 - 1));
    if (edge_hit)                return C_GREEN;
    else if (eye_row && eye_col) return C_BLACK;
    else                         return C_YELLOW;
  endfunction

  // Tail: checkerboard of quarter-tile squares.
  function automatic rgb_t tail_px(int c, int r, int t);
    bit cb;
    bit rb;
    cb = (c & (t / 4)) != 0;
    rb = (r & (t / 4)) != 0;
    return (cb ^ rb) ? C_GREEN : C_CYAN;
  endfunction

  // Apple: green stem on top of a red disc, white around it.
  function automatic rgb_t apple_px(int c, int r, int t);
    int dx;
    int dy;
    dx = 2 * c - (t - 1);
    dy = 2 * r - (t - 1);
    if (((c == t / 2 - 1) || (c == t / 2)) && (r <= 2))
      return C_GREEN;
    else if (dx * dx + dy * dy <= (t - 2) * (t - 2))
      return C_RED;
    else
      return C_WHITE;
  endfunction

endpackage

// File: rtl/tsr_sprite_rom.sv
module tsr_sprite_rom
  import tsr_pkg::*;
#(
  parameter int   TILE_LOG2   = 4,
  parameter ent_e SPRITE_KIND = ENT_HEAD
) (
  input  logic [TILE_LOG2-1:0] col_i,
  input  logic [TILE_LOG2-1:0] row_i,
  output rgb_t                 pix_o
);

  localparam int TILE = 1 << TILE_LOG2;

  generate
    if (SPRITE_KIND == ENT_HEAD) begin : g_head
      always_comb pix_o = head_px(int'(col_i), int'(row_i), TILE);
    end else if (SPRITE_KIND == ENT_TAIL) begin : g_tail
      always_comb pix_o = tail_px(int'(col_i), int'(row_i), TILE);
    end else if (SPRITE_KIND == ENT_APPLE) begin : g_apple
      always_comb pix_o = apple_px(int'(col_i), int'(row_i), TILE);
    end else begin : g_blank
      always_comb pix_o = C_WHITE;
    end
  endgenerate

endmodule

// File: rtl/tsr_colour_reg.sv
module tsr_colour_reg
  import tsr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic active_i,
  input  rgb_t pix_i,
  output rgb_t rgb_q
);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)          rgb_q <= C_BLACK;
    else if (!active_i) rgb_q <= C_BLACK;
    else                rgb_q <= pix_i;
  end

  // R1: the output is black at every edge that sees reset high.
  assert_reset_black_R1: assert property (@(posedge clk_i)
    rst_i |-> (rgb_q == C_BLACK));

  // R3: a blanked pixel leaves black on the next cycle.
  assert_blank_black_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !active_i |=> (rgb_q == C_BLACK));

endmodule

// File: rtl/tile_sprite_renderer.sv
module tile_sprite_renderer
  import tsr_pkg::*;
#(
  parameter int COORD_W   = 10,
  parameter int TILE_LOG2 = 4,
  parameter int H_ACTIVE  = 640,
  parameter int V_ACTIVE  = 480
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               active_i,
  input  logic [COORD_W-1:0] px_x_i,
  input  logic [COORD_W-1:0] px_y_i,
  input  logic [ENT_W-1:0]   ent_i,
  output logic               red_o,
  output logic               green_o,
  output logic               blue_o
);

  logic [TILE_LOG2-1:0] tile_col;
  logic [TILE_LOG2-1:0] tile_row;
  rgb_t                 sprite_pix [N_ENT];
  rgb_t                 lookup;
  rgb_t                 rgb_q;

  // The tile size is a power of two, so the offset is the low coordinate bits.
  assign tile_col = px_x_i[TILE_LOG2-1:0];
  assign tile_row = px_y_i[TILE_LOG2-1:0];

  assign sprite_pix[0] = C_WHITE;

  generate
    for (genvar k = 1; k < N_ENT; k++) begin : g_sprite
      tsr_sprite_rom #(
        .TILE_LOG2  (TILE_LOG2),
        .SPRITE_KIND(ent_e'(k))
      ) rom_i (
        .col_i(tile_col),
        .row_i(tile_row),
        .pix_o(sprite_pix[k])
      );
    end
  endgenerate

  assign lookup = sprite_pix[ent_i];

  tsr_colour_reg out_reg_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .active_i(active_i),
    .pix_i   (lookup),
    .rgb_q   (rgb_q)
  );

  assign red_o   = rgb_q.red;
  assign green_o = rgb_q.grn;
  assign blue_o  = rgb_q.blu;

  // R3: coordinates flagged active must lie inside the visible raster.
  assert_coord_in_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    active_i |-> ((int'(px_x_i) < H_ACTIVE) && (int'(px_y_i) < V_ACTIVE)));

  // R4: an empty tile is white one cycle later.
  assert_empty_white_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_i && ent_i == ENT_EMPTY) |=> (red_o && green_o && blue_o));

  // R6: the left column of a head tile is green one cycle later.
  assert_head_frame_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_i && ent_i == ENT_HEAD && tile_col == '0)
      |=> ({blue_o, green_o, red_o} == 3'b010));

endmodule

// File: tb/tile_sprite_renderer_tb_top.sv
module tile_sprite_renderer_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       active;
  logic [9:0] px_x;
  logic [9:0] px_y;
  logic [1:0] ent;
  logic       red;
  logic       green;
  logic       blue;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic [2:0] prev_exp = 3'b000;

  always #2 clk = ~clk;

  tile_sprite_renderer dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .active_i(active),
    .px_x_i  (px_x),
    .px_y_i  (px_y),
    .ent_i   (ent),
    .red_o   (red),
    .green_o (green),
    .blue_o  (blue)
  );

  // Expected colour as {B,G,R}, computed directly from the requirements.
  function automatic logic [2:0] exp_px(int e, int x, int y, bit act);
    int c;
    int r;
    int dx;
    int dy;
    if (!act) return 3'b000;
    c = x % 16;
    r = y % 16;
    case (e)
      0: return 3'b111;
      1: begin
        if (c == 0 || c == 15 || r == 0 || r == 15) return 3'b010;
        if ((r == 4 || r == 5) && (c == 4 || c == 5 || c == 10 || c == 11))
          return 3'b000;
        return 3'b011;
      end
      2: return (((c / 4) % 2) != ((r / 4) % 2)) ? 3'b010 : 3'b110;
      default: begin
        dx = 2 * c - 15;
        dy = 2 * r - 15;
        if ((c == 7 || c == 8) && r <= 2) return 3'b010;
        if (dx * dx + dy * dy <= 196) return 3'b001;
        return 3'b111;
      end
    endcase
  endfunction

  task automatic check(string req, logic [2:0] exp_v);
    logic [2:0] got;
    got = {blue, green, red};
    n_tests++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (x=%0d y=%0d ent=%0d act=%0b)",
               req, got, exp_v, px_x, px_y, ent, active);
    end
  endtask

  // Called at a falling edge: drive, confirm hold, then check after the edge.
  task automatic apply(int e, int x, int y, bit act, string req);
    logic [2:0] nexp;
    ent    = 2'(e);
    px_x   = 10'(x);
    px_y   = 10'(y);
    active = act;
    nexp   = exp_px(e, x, y, act);
    #1;
    check("R2 hold", prev_exp);
    @(negedge clk);
    check(req, nexp);
    prev_exp = nexp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  int tx [3] = '{0, 39, 17};
  int ty [3] = '{0, 29, 5};

  initial begin
    rst    = 1'b1;
    active = 1'b0;
    px_x   = '0;
    px_y   = '0;
    ent    = 2'd1;
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'b000);
    active = 1'b1;
    @(negedge clk);
    check("R1 reset with active input", 3'b000);
    rst = 1'b0;
    prev_exp = 3'b000;

    // R5 R6 R7 R8 R9: every offset of every entity in three tiles.
    for (int t = 0; t < 3; t++) begin
      for (int e = 0; e < 4; e++) begin
        for (int r = 0; r < 16; r++) begin
          for (int c = 0; c < 16; c++) begin
            apply(e, tx[t] * 16 + c, ty[t] * 16 + r, 1'b1,
                  (e == 0) ? "R4 empty" : (e == 1) ? "R6 head" :
                  (e == 2) ? "R7 tail" : "R8 apple");
          end
        end
      end
    end

    // R3: blanking falls in the same cycle as every entity lookup.
    for (int e = 0; e < 4; e++) begin
      apply(e, 100 + e, 50, 1'b0, "R3 blank in raster");
      apply(e, 3, 7, 1'b1, "R5 after blank");
      apply(e, 700, 500 + e, 1'b0, "R3 blank outside raster");
    end

    // R1: asynchronous reset in the middle of a head pixel.
    apply(1, 16 * 3 + 7, 16 * 2 + 8, 1'b1, "R6 head before reset");
    #0.5;
    rst = 1'b1;
    #0.5;
    check("R1 async clear before edge", 3'b000);
    @(negedge clk);
    check("R1 held in reset", 3'b000);
    rst = 1'b0;
    prev_exp = 3'b000;
    apply(3, 16 * 10 + 8, 16 * 12 + 8, 1'b1, "R8 apple after reset");
    apply(2, 639, 479, 1'b1, "R9 last pixel tail");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule